// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block records every cache-line request that a multi-threaded core has sent downstream and not yet seen answered. Each hardware thread owns two small tables, one for read-class requests and one for write-class requests, and every entry is keyed by the line address. An entry holds the request kind, its prefetch bit and the timestamp it was issued with. The tracker tells the requester whether a new request may go out, records it, matches completions back to entries and keeps running totals of what is in flight.

A completion names only a line and whether it answers a read or a write. When more than one thread holds that line in a table of the matching class, the entry with the oldest timestamp is retired first. Retiring a demand request raises a one-cycle hit pulse that carries the thread and the request kind. Retiring a prefetch raises nothing. A watchdog re-examines the ages of the live entries at a fixed period while anything is outstanding and raises a sticky flag when any entry has waited at least the threshold.

The `iss_ready` output is advisory. A requester that honours it never places the same line in two tables. The tracker still accepts an issue whenever the target table has room and the global limit has not been reached, and it resolves any duplicates that result by age.

Top module: `otrk_tracker`

## Requirements
- R1: Request kinds with bit 3 of `iss_kind` set (store 8, transactional store 9, transactional exclusive load 10, atomic 11) go to the issuing thread's write table. All other kinds (load 0, fetch 1, transactional load 2, transaction begin 3, transaction commit 4) go to its read table. A completion with `cmp_write` = 1 searches only write tables, and one with `cmp_write` = 0 searches only read tables.
- R2: The line address is `iss_addr` with its low OFS_W (4) bits dropped. Two addresses that differ only in those bits name the same line.
- R3: An issue whose line is already held in the target table overwrites that entry's kind, prefetch bit and timestamp. It raises `iss_dup`, keeps `iss_new` low and leaves `cnt_out` unchanged.
- R4: `iss_ready` is low and nothing is allocated while `cnt_out` equals MAX_OUT. `cnt_out` never exceeds MAX_OUT.
- R5: `iss_ready` is low while any table of any thread holds the requested line.
- R6: When the target table is full and does not hold the line, `iss_ready` and `iss_new` are low and the issue has no effect.
- R7: A matching completion retires the entry with the largest age (now minus timestamp) among all threads' tables of that class. On a tie the lowest thread number wins. `hit_thread` reports the retired thread one cycle later.
- R8: `cnt_out` equals the number of valid entries across all tables. It rises by one for each allocation and falls by one for each retirement.
- R9: While entries are outstanding, the tracker scans their ages every THRESH cycles and sets the sticky `deadlock` flag if any age is at least THRESH. It does not set the flag when every entry retires younger than that.
- R10: Retiring a prefetch entry raises no `hit_valid`. Retiring a demand entry raises `hit_valid` for one cycle with its `hit_kind`.
- R11: `cnt_pf` counts valid entries with the prefetch bit set. `cnt_demand` counts valid non-prefetch entries, except read-table entries of kind transaction begin (3) or transaction commit (4).
- R12: A completion that matches no entry sets the sticky `miss_err` flag and changes no count or entry.
- R13: After reset, all tables are empty, all counts and flags are 0, and `iss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_thread | input | TW | Issuing thread |
| iss_addr | input | ADDR_W | Request byte address |
| iss_kind | input | 4 | Request kind; bit 3 selects the write class |
| iss_pf | input | 1 | Request is a prefetch |
| iss_stamp | input | TS_W | Issue timestamp |
| iss_ready | output | 1 | A new line may be issued now |
| iss_new | output | 1 | Issue allocated a new entry (go downstream) |
| iss_dup | output | 1 | Issue overwrote an entry already present |
| cmp_valid | input | 1 | Completion present |
| cmp_line | input | LINE_W | Completed line address |
| cmp_write | input | 1 | Completion answers a write-class request |
| hit_valid | output | 1 | Demand request retired (one cycle) |
| hit_thread | output | TW | Thread of the retired request |
| hit_kind | output | 4 | Kind of the retired request |
| cnt_out | output | CW | Entries outstanding |
| cnt_demand | output | CW | Outstanding demand entries |
| cnt_pf | output | CW | Outstanding prefetch entries |
| time_now | output | TS_W | Tracker time base used for ages |
| miss_err | output | 1 | Sticky: completion matched nothing |
| deadlock | output | 1 | Sticky: an entry aged past the threshold |

## Verification
The hardest state to reach is two threads holding the same line in tables of the same class, because a requester that obeys `iss_ready` never creates it. The stimulus deliberately issues while ready is low, on a line owned by another thread, with a timestamp set well in the past. Two completions on that line must then retire the older thread first and the younger one second. The watchdog needs a stale entry without waiting thousands of cycles, so the bench reads `time_now` and stamps a request far behind it.

// File: rtl/otrk_pkg.sv
package otrk_pkg;
    parameter int ADDR_W = 16;
    parameter int OFS_W  = 4;
    parameter int TS_W   = 16;
    localparam int LINE_W = ADDR_W - OFS_W;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [TS_W-1:0]   stamp_t;
    typedef logic [3:0]        kind_t;

    localparam kind_t K_LOAD      = 4'd0;
    localparam kind_t K_FETCH     = 4'd1;
    localparam kind_t K_LOAD_TX   = 4'd2;
    localparam kind_t K_TX_BEGIN  = 4'd3;
    localparam kind_t K_TX_COMMIT = 4'd4;
    localparam kind_t K_STORE     = 4'd8;
    localparam kind_t K_STORE_TX  = 4'd9;
    localparam kind_t K_LOADX_TX  = 4'd10;
    localparam kind_t K_ATOMIC    = 4'd11;

    typedef struct packed {
        line_t  line;
        kind_t  kind;
        logic   pf;
        stamp_t stamp;
    } slot_t;

    function automatic logic kind_is_write(kind_t k);
        return k[3];
    endfunction

    function automatic line_t addr_to_line(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic slot_is_demand(slot_t s, logic wr_tbl);
        return !s.pf && (wr_tbl || !(s.kind == K_TX_BEGIN || s.kind == K_TX_COMMIT));
    endfunction
endpackage

// File: rtl/otrk_table.sv
module otrk_table
    import otrk_pkg::*;
#(
    parameter int ENTRIES = 2,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  line_t             probe_line,
    output logic              probe_hit,
    output logic              full,
    input  logic              put_en,
    input  slot_t             put_slot,
    input  line_t             done_line,
    output logic              done_hit,
    output slot_t             done_slot,
    output logic [IW-1:0]     done_idx,
    input  logic              clr_en,
    input  logic [IW-1:0]     clr_idx,
    output logic [ENTRIES-1:0] valid_o,
    output slot_t             slot_o [ENTRIES]
);
    logic [ENTRIES-1:0] valid_q;
    slot_t              slot_q [ENTRIES];
    logic [IW-1:0]      probe_idx;
    logic [IW-1:0]      free_idx;

    // Lowest index wins for free slot and for matches.
    always_comb begin
        probe_hit = 1'b0;
        probe_idx = '0;
        full      = 1'b1;
        free_idx  = '0;
        done_hit  = 1'b0;
        done_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                full     = 1'b0;
                free_idx = IW'(i);
            end
            if (valid_q[i] && slot_q[i].line == probe_line) begin
                probe_hit = 1'b1;
                probe_idx = IW'(i);
            end
            if (valid_q[i] && slot_q[i].line == done_line) begin
                done_hit = 1'b1;
                done_idx = IW'(i);
            end
        end
    end

    assign done_slot = slot_q[done_idx];
    assign valid_o   = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (put_en && !probe_hit && !full)
                valid_q[free_idx] <= 1'b1;
            if (clr_en)
                valid_q[clr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (put_en) begin
            if (probe_hit)
                slot_q[probe_idx] <= put_slot;
            else if (!full)
                slot_q[free_idx] <= put_slot;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_out
        assign slot_o[e] = slot_q[e];
    end
endmodule

// File: rtl/otrk_oldest.sv
module otrk_oldest
    import otrk_pkg::*;
#(
    parameter int THREADS = 2,
    localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic [THREADS-1:0] cand,
    input  stamp_t             age [THREADS],
    output logic               found,
    output logic [TW-1:0]      pick
);
    stamp_t best;

    // Strict comparison keeps the lowest thread on equal ages.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (cand[t] && (!found || age[t] > best)) begin
                found = 1'b1;
                pick  = TW'(t);
                best  = age[t];
            end
        end
    end
endmodule

// File: rtl/otrk_watchdog.sv
module otrk_watchdog
    import otrk_pkg::*;
#(
    parameter int NT     = 8,
    parameter int THRESH = 200,
    localparam int WW = $clog2(THRESH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  stamp_t        now,
    input  logic [NT-1:0] live,
    input  stamp_t        stamps [NT],
    output logic          alarm
);
    logic [WW-1:0] tick_q;
    logic          stale;

    always_comb begin
        stale = 1'b0;
        for (int i = 0; i < NT; i++)
            if (live[i] && (stamp_t'(now - stamps[i]) >= stamp_t'(THRESH)))
                stale = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            alarm  <= 1'b0;
        end else if (live == '0) begin
            tick_q <= '0;
        end else if (tick_q == WW'(THRESH - 1)) begin
            tick_q <= '0;
            if (stale)
                alarm <= 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/otrk_tracker.sv
module otrk_tracker
    import otrk_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int ENTRIES = 2,
    parameter int MAX_OUT = 6,
    parameter int THRESH  = 200,
    localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int NT = THREADS * 2 * ENTRIES,
    localparam int CW = $clog2(NT + 1),
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [TW-1:0]     iss_thread,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [3:0]        iss_kind,
    input  logic              iss_pf,
    input  logic [TS_W-1:0]   iss_stamp,
    output logic              iss_ready,
    output logic              iss_new,
    output logic              iss_dup,
    input  logic              cmp_valid,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic              cmp_write,
    output logic              hit_valid,
    output logic [TW-1:0]     hit_thread,
    output logic [3:0]        hit_kind,
    output logic [CW-1:0]     cnt_out,
    output logic [CW-1:0]     cnt_demand,
    output logic [CW-1:0]     cnt_pf,
    output logic [TS_W-1:0]   time_now,
    output logic              miss_err,
    output logic              deadlock
);
    line_t  iss_line;
    slot_t  new_slot;
    logic   tgt_k;
    logic   thr_ok;
    stamp_t now_q;

    logic           p_hit  [THREADS][2];
    logic           t_full [THREADS][2];
    logic           put_en [THREADS][2];
    logic           clr_en [THREADS][2];
    logic           d_hit  [THREADS][2];
    slot_t          d_slot [THREADS][2];
    logic [IW-1:0]  d_idx  [THREADS][2];

    logic [NT-1:0]  all_v;
    slot_t          all_s   [NT];
    stamp_t         all_ts  [NT];

    logic [THREADS-1:0] cand;
    stamp_t             cand_age [THREADS];
    logic               found;
    logic [TW-1:0]      pick;
    slot_t              ret_slot;
    logic               retire;

    logic own_hit, tgt_full, any_hit, cap_ok;

    assign iss_line = addr_to_line(iss_addr);
    assign tgt_k    = kind_is_write(iss_kind);
    assign thr_ok   = (int'(iss_thread) < THREADS);
    assign new_slot = '{line: iss_line, kind: iss_kind, pf: iss_pf, stamp: iss_stamp};
    assign time_now = now_q;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        for (genvar k = 0; k < 2; k++) begin : g_cls
            logic [ENTRIES-1:0] tv;
            slot_t              ts [ENTRIES];

            otrk_table #(.ENTRIES(ENTRIES)) u_tbl (
                .clk        (clk),
                .rst        (rst),
                .probe_line (iss_line),
                .probe_hit  (p_hit[t][k]),
                .full       (t_full[t][k]),
                .put_en     (put_en[t][k]),
                .put_slot   (new_slot),
                .done_line  (cmp_line),
                .done_hit   (d_hit[t][k]),
                .done_slot  (d_slot[t][k]),
                .done_idx   (d_idx[t][k]),
                .clr_en     (clr_en[t][k]),
                .clr_idx    (d_idx[t][k]),
                .valid_o    (tv),
                .slot_o     (ts)
            );

            assign put_en[t][k] = iss_valid && thr_ok && (iss_thread == TW'(t)) &&
                                  (tgt_k == k[0]) && (own_hit || cap_ok);
            assign clr_en[t][k] = retire && (pick == TW'(t)) && (cmp_write == k[0]);

            for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
                assign all_v[(t*2+k)*ENTRIES + e]  = tv[e];
                assign all_s[(t*2+k)*ENTRIES + e]  = ts[e];
                assign all_ts[(t*2+k)*ENTRIES + e] = ts[e].stamp;
            end
        end

        assign cand[t]     = d_hit[t][cmp_write];
        assign cand_age[t] = stamp_t'(now_q - d_slot[t][cmp_write].stamp);
    end

    // Issue side: capacity versus line conflicts.
    always_comb begin
        own_hit  = 1'b0;
        tgt_full = 1'b1;
        if (thr_ok) begin
            own_hit  = p_hit[iss_thread][tgt_k];
            tgt_full = t_full[iss_thread][tgt_k];
        end
        any_hit = 1'b0;
        for (int t = 0; t < THREADS; t++)
            for (int k = 0; k < 2; k++)
                any_hit = any_hit | p_hit[t][k];
    end

    assign cap_ok    = thr_ok && (cnt_out < CW'(MAX_OUT)) && !tgt_full;
    assign iss_ready = cap_ok && !any_hit;
    assign iss_new   = iss_valid && !own_hit && cap_ok;
    assign iss_dup   = iss_valid && thr_ok && own_hit;

    // Completion side.
    otrk_oldest #(.THREADS(THREADS)) u_oldest (
        .cand  (cand),
        .age   (cand_age),
        .found (found),
        .pick  (pick)
    );

    assign retire   = cmp_valid && found;
    assign ret_slot = d_slot[pick][cmp_write];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_out    <= '0;
            hit_valid  <= 1'b0;
            hit_thread <= '0;
            hit_kind   <= '0;
            miss_err   <= 1'b0;
        end else begin
            cnt_out    <= cnt_out + CW'(iss_new) - CW'(retire);
            hit_valid  <= retire && !ret_slot.pf;
            hit_thread <= pick;
            hit_kind   <= ret_slot.kind;
            if (cmp_valid && !found)
                miss_err <= 1'b1;
        end
    end

    // Demand and prefetch totals from the live entries.
    always_comb begin
        cnt_demand = '0;
        cnt_pf     = '0;
        for (int i = 0; i < NT; i++) begin
            if (all_v[i]) begin
                if (all_s[i].pf)
                    cnt_pf = cnt_pf + 1'b1;
                else if (slot_is_demand(all_s[i], ((i / ENTRIES) % 2) == 1))
                    cnt_demand = cnt_demand + 1'b1;
            end
        end
    end

    otrk_watchdog #(.NT(NT), .THRESH(THRESH)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .now    (now_q),
        .live   (all_v),
        .stamps (all_ts),
        .alarm  (deadlock)
    );
endmodule

// File: rtl/otrk_tracker_chk.sv
module otrk_tracker_chk #(
    parameter int MAX_OUT = 6,
    parameter int NT      = 8,
    parameter int CW      = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmp_valid,
    input logic          iss_ready,
    input logic          iss_new,
    input logic          iss_dup,
    input logic [CW-1:0] cnt_out,
    input logic [NT-1:0] all_v,
    input logic          hit_valid,
    input logic          miss_err,
    input logic          deadlock
);
    assert_count_match_R8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_out) == $countones(all_v));

    assert_cap_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_out >= CW'(MAX_OUT)) |-> (!iss_ready && !iss_new));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_out <= CW'(MAX_OUT));

    assert_dup_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        iss_dup |-> (!iss_ready && !iss_new));

    assert_dup_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_dup && !cmp_valid) |=> $stable(cnt_out));

    assert_hit_needs_cmp_R10: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(cmp_valid));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        miss_err |=> miss_err);

    assert_dl_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

    assert_dl_needs_entries_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(deadlock) |-> ($past(cnt_out) != '0));
endmodule

bind otrk_tracker otrk_tracker_chk #(.MAX_OUT(MAX_OUT), .NT(NT), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .iss_ready (iss_ready),
    .iss_new   (iss_new),
    .iss_dup   (iss_dup),
    .cnt_out   (cnt_out),
    .all_v     (all_v),
    .hit_valid (hit_valid),
    .miss_err  (miss_err),
    .deadlock  (deadlock)
);

// File: tb/otrk_tracker_bench.sv
module otrk_tracker_bench;
    localparam int THRESH = 200;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [0:0]  iss_thread;
    logic [15:0] iss_addr;
    logic [3:0]  iss_kind;
    logic        iss_pf;
    logic [15:0] iss_stamp;
    logic        iss_ready, iss_new, iss_dup;
    logic        cmp_valid;
    logic [11:0] cmp_line;
    logic        cmp_write;
    logic        hit_valid;
    logic [0:0]  hit_thread;
    logic [3:0]  hit_kind;
    logic [3:0]  cnt_out, cnt_demand, cnt_pf;
    logic [15:0] time_now;
    logic        miss_err, deadlock;

    int total = 0;
    int bad   = 0;

    otrk_tracker #(.THREADS(2), .ENTRIES(2), .MAX_OUT(6), .THRESH(THRESH)) u_otrk_tracker (
        .clk, .rst, .iss_valid, .iss_thread, .iss_addr, .iss_kind, .iss_pf, .iss_stamp,
        .iss_ready, .iss_new, .iss_dup, .cmp_valid, .cmp_line, .cmp_write,
        .hit_valid, .hit_thread, .hit_kind, .cnt_out, .cnt_demand, .cnt_pf,
        .time_now, .miss_err, .deadlock
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [0:0]  thr;
        logic [15:0] addr;
        logic [3:0]  kind;
        logic        pf;
        logic        ready;
        logic        newl;
        logic        dup;
        logic [3:0]  cnt;
    } vec_t;

    // kinds: 0 load, 1 fetch, 2 tx load, 3 tx begin, 8 store, 9 tx store, 11 atomic
    localparam vec_t VECS [10] = '{
        '{1'd0, 16'h1230, 4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 load -> read table
        '{1'd0, 16'h1238, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R2 R3 same line
        '{1'd1, 16'h1234, 4'd8,  1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R5 line busy elsewhere
        '{1'd0, 16'h2000, 4'd8,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R1 store pf
        '{1'd0, 16'h3000, 4'd11, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // R1 atomic
        '{1'd0, 16'h4000, 4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R6 table full
        '{1'd1, 16'h5000, 4'd1,  1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // fetch pf
        '{1'd1, 16'h6000, 4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 4'd6},  // tx begin
        '{1'd0, 16'h7000, 4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R4 limit
        '{1'd0, 16'h1230, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 4'd6}   // R3 overwrite as pf
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive at posedge+1, sample combinational at +3, commit at next edge.
    task automatic issue(input logic [0:0] t, input logic [15:0] a, input logic [3:0] k,
                         input logic pf, input logic [15:0] ts,
                         output logic r, output logic n, output logic d);
        iss_valid = 1'b1; iss_thread = t; iss_addr = a; iss_kind = k;
        iss_pf = pf; iss_stamp = ts;
        #2;
        r = iss_ready; n = iss_new; d = iss_dup;
        @(posedge clk); #1;
        iss_valid = 1'b0;
    endtask

    task automatic complete(input logic [11:0] line, input logic wr);
        cmp_valid = 1'b1; cmp_line = line; cmp_write = wr;
        @(posedge clk); #1;
        cmp_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic r, n, d;
        rst = 1'b1; iss_valid = 0; iss_thread = 0; iss_addr = 0; iss_kind = 0;
        iss_pf = 0; iss_stamp = 0; cmp_valid = 0; cmp_line = 0; cmp_write = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R13 ready", iss_ready, 1);
        chk("R13 cnt", cnt_out, 0);
        chk("R13 flags", {miss_err, deadlock, hit_valid}, 0);
        @(posedge clk); #1;

        // Vector walk over the issue path.
        for (int i = 0; i < 10; i++) begin
            issue(VECS[i].thr, VECS[i].addr, VECS[i].kind, VECS[i].pf, time_now, r, n, d);
            chk($sformatf("R4/R5/R6 ready v%0d", i), r, VECS[i].ready);
            chk($sformatf("R3 new v%0d", i), n, VECS[i].newl);
            chk($sformatf("R3 dup v%0d", i), d, VECS[i].dup);
            chk($sformatf("R8 cnt v%0d", i), cnt_out, VECS[i].cnt);
        end
        chk("R11 demand", cnt_demand, 2);
        chk("R11 prefetch", cnt_pf, 3);

        // Overwritten entry is now a prefetch: silent retire.
        complete(12'h123, 1'b0);
        chk("R10 R3 silent", hit_valid, 0);
        chk("R8 cnt after pf retire", cnt_out, 5);

        complete(12'h300, 1'b1);
        chk("R1 R10 hit", hit_valid, 1);
        chk("R1 hit thread", hit_thread, 0);
        chk("R1 hit kind", hit_kind, 11);
        chk("R8 cnt", cnt_out, 4);

        complete(12'h999, 1'b0);
        chk("R12 err", miss_err, 1);
        chk("R12 cnt", cnt_out, 4);
        chk("R12 no hit", hit_valid, 0);

        // Older duplicate on thread 0 for a line thread 1 holds.
        issue(1'd0, 16'h1230, 4'd8, 1'b0, time_now - 16'd100, r, n, d);
        chk("R7 dup alloc", n, 1);
        chk("R5 ready low", r, 0);
        complete(12'h123, 1'b1);
        chk("R7 oldest first", hit_thread, 0);
        chk("R7 kind", hit_kind, 8);
        complete(12'h123, 1'b1);
        chk("R7 second", hit_thread, 1);
        chk("R7 valid", hit_valid, 1);

        // Drain.
        complete(12'h200, 1'b1);
        chk("R10 pf store silent", hit_valid, 0);
        complete(12'h500, 1'b0);
        chk("R10 pf fetch silent", hit_valid, 0);
        complete(12'h600, 1'b0);
        chk("R10 tx begin hit", hit_kind, 3);
        chk("R8 drained", cnt_out, 0);
        chk("R11 drained", {cnt_demand, cnt_pf}, 0);
        chk("R9 no deadlock", deadlock, 0);

        // Stale entry trips the watchdog.
        issue(1'd1, 16'h8000, 4'd0, 1'b0, time_now - 16'd250, r, n, d);
        chk("R9 stale alloc", n, 1);
        repeat (2 * THRESH + 50) @(posedge clk);
        #1;
        chk("R9 deadlock", deadlock, 1);
        chk("R12 err sticky", miss_err, 1);

        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        #2;
        chk("R13 reset cnt", cnt_out, 0);
        chk("R13 reset flags", {miss_err, deadlock}, 0);
        chk("R13 reset ready", iss_ready, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule